// File: doc/BRIEF.md
# Vector Quad/Rest Alignment Unit

This block sits on the data path between a 16-byte vector register and a byte-addressed 128-bit memory line. It lines up the bytes for one vector load or store. Each cycle it takes an operation code, a direction, the byte offset of the address inside its 16-byte line, and a register element index. It also takes the current register contents and the current memory line. A load yields the merged register and a per-byte register write mask. A store yields the merged memory line and a per-byte memory write mask. Both results appear on registered outputs one clock later.

Normal moves carry 1, 2, 4 or 8 bytes between the memory offset and the register element. An unaligned 128-bit vector is moved as a pair of operations. The "head" operation covers the bytes from the address to the end of its line and fills the low-numbered register bytes. The "tail" operation covers the bytes from the line start up to the address and fills the high-numbered register bytes. Together the two operations cover the whole register. Illegal alignments raise no error. They give a fixed partial move.

Byte numbering is big-endian. Byte i of a 128-bit line or register occupies bits [127-8i : 120-8i]. Bit i of every mask belongs to byte i.

Top module: `vqr_align`

## Requirements
- R1: Operation codes: 0 = byte (1 byte), 1 = short (2), 2 = long (4), 3 = double (8), 4 = head, 5 = tail, 6 and 7 = no operation. A normal load (codes 0 to 3, is_store_i = 0) copies memory byte off+k into register byte elem+k for k from 0 to size-1, sets the matching bits of vreg_be_o, and uses no other alignment check.
- R2: A normal store copies register byte elem+k into memory byte off+k, with the same range of k as R1, and sets the matching bits of mem_be_o.
- R3: Any byte pair whose memory index or register index would pass 15 is dropped. Neither byte is written and neither mask bit is set.
- R4: A head move (code 4) with offset o pairs memory bytes o..15 with register bytes 0..15-o, which is 16-o bytes.
- R5: A tail move (code 5) with offset o pairs memory bytes 0..o-1 with register bytes 16-o..15.
- R6: A tail move with offset 0 moves nothing. Both masks are zero and both data outputs equal their inputs.
- R7: A head move with offset 0 moves all 16 bytes, so the active mask is 16'hFFFF.
- R8: Every byte whose mask bit is clear equals the matching byte of vreg_i (load) or mem_i (store).
- R9: Codes 6 and 7 leave both masks zero and pass vreg_i and mem_i through unchanged.
- R10: A load keeps mem_be_o at zero and passes mem_i to mem_o. A store keeps vreg_be_o at zero and passes vreg_i to vreg_o.
- R11: All outputs are zero while rst_ni is low. After reset, the outputs show the result for the inputs present at the previous rising edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (R1) |
| is_store_i | input | 1 | 1 = store, 0 = load |
| off_i | input | 4 | Byte offset of the address inside its 16-byte line |
| elem_i | input | 4 | Register element (byte) index |
| vreg_i | input | 128 | Current register contents |
| mem_i | input | 128 | Current memory line |
| vreg_o | output | 128 | Merged register (load result) |
| vreg_be_o | output | 16 | Register byte write mask |
| mem_o | output | 128 | Merged memory line (store result) |
| mem_be_o | output | 16 | Memory byte write mask |

## Verification
Several properties are checked on every cycle. These cover the mask population for head, tail and byte moves, the empty tail at offset 0, the no-operation codes, the silent side of each direction, and that bytes with a clear mask bit keep their values. The bench scenarios are needed for the exact byte routing. That means checking which source byte lands in which destination slot for every size, offset and element. It also covers the clipping at the line edge and the way a head and tail pair joins up into one full vector. These results are compared against a bench model over random and directed inputs.

// File: rtl/vqr_pkg.sv
package vqr_pkg;
  parameter int LINE_BYTES = 16;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;

  typedef enum logic [2:0] {
    OP_BYTE   = 3'd0,
    OP_SHORT  = 3'd1,
    OP_LONG   = 3'd2,
    OP_DOUBLE = 3'd3,
    OP_HEAD   = 3'd4,
    OP_TAIL   = 3'd5,
    OP_NOP6   = 3'd6,
    OP_NOP7   = 3'd7
  } vqr_op_e;
endpackage

// File: rtl/vqr_decode.sv
module vqr_decode
  import vqr_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] elem_i,
  output logic [OFF_W-1:0] reg_start_o,
  output logic [OFF_W-1:0] mem_start_o,
  output logic [OFF_W:0]   count_o
);
  vqr_op_e op;
  assign op = vqr_op_e'(op_i);

  always_comb begin
    reg_start_o = '0;
    mem_start_o = '0;
    count_o     = '0;
    unique case (op)
      OP_BYTE, OP_SHORT, OP_LONG, OP_DOUBLE: begin
        reg_start_o = elem_i;
        mem_start_o = off_i;
        count_o     = (OFF_W+1)'(1) << op_i[1:0];
      end
      OP_HEAD: begin
        reg_start_o = '0;
        mem_start_o = off_i;
        count_o     = (OFF_W+1)'(LINE_BYTES) - {1'b0, off_i};
      end
      OP_TAIL: begin
        // modulo line size: 0 - off == LINE_BYTES - off
        reg_start_o = OFF_W'(0) - off_i;
        mem_start_o = '0;
        count_o     = {1'b0, off_i};
      end
      default: count_o = '0;
    endcase
  end
endmodule

// File: rtl/vqr_lane.sv
module vqr_lane
  import vqr_pkg::*;
(
  input  logic [OFF_W-1:0]      dst_start_i,
  input  logic [OFF_W-1:0]      src_start_i,
  input  logic [OFF_W:0]        count_i,
  input  logic [LINE_W-1:0]     src_i,
  input  logic [LINE_W-1:0]     dst_i,
  output logic [LINE_W-1:0]     data_o,
  output logic [LINE_BYTES-1:0] be_o
);
  localparam int IW = OFF_W + 2;

  for (genvar d = 0; d < LINE_BYTES; d++) begin : g_byte
    logic [IW-1:0] rel;
    logic [IW-1:0] sidx;
    logic          hit;
    logic [7:0]    pick;

    always_comb begin
      rel  = IW'(d) - IW'(dst_start_i);
      sidx = IW'(src_start_i) + rel;
      hit  = (IW'(d) >= IW'(dst_start_i)) && (rel < IW'(count_i))
             && (sidx < IW'(LINE_BYTES));
      pick = 8'h00;
      for (int s = 0; s < LINE_BYTES; s++) begin
        if (sidx == IW'(s)) pick = src_i[LINE_W-1-8*s -: 8];
      end
    end

    assign be_o[d]                   = hit;
    assign data_o[LINE_W-1-8*d -: 8] = hit ? pick : dst_i[LINE_W-1-8*d -: 8];
  end
endmodule

// File: rtl/vqr_align.sv
module vqr_align
  import vqr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            op_i,
  input  logic                  is_store_i,
  input  logic [OFF_W-1:0]      off_i,
  input  logic [OFF_W-1:0]      elem_i,
  input  logic [LINE_W-1:0]     vreg_i,
  input  logic [LINE_W-1:0]     mem_i,
  output logic [LINE_W-1:0]     vreg_o,
  output logic [LINE_BYTES-1:0] vreg_be_o,
  output logic [LINE_W-1:0]     mem_o,
  output logic [LINE_BYTES-1:0] mem_be_o
);
  logic [OFF_W-1:0]      reg_start, mem_start;
  logic [OFF_W:0]        count;
  logic [LINE_W-1:0]     ld_data, st_data;
  logic [LINE_BYTES-1:0] ld_be, st_be;

  vqr_decode u_decode (
    .op_i        (op_i),
    .off_i       (off_i),
    .elem_i      (elem_i),
    .reg_start_o (reg_start),
    .mem_start_o (mem_start),
    .count_o     (count)
  );

  // load: memory -> register
  vqr_lane u_ld_lane (
    .dst_start_i (reg_start),
    .src_start_i (mem_start),
    .count_i     (count),
    .src_i       (mem_i),
    .dst_i       (vreg_i),
    .data_o      (ld_data),
    .be_o        (ld_be)
  );

  // store: register -> memory
  vqr_lane u_st_lane (
    .dst_start_i (mem_start),
    .src_start_i (reg_start),
    .count_i     (count),
    .src_i       (vreg_i),
    .dst_i       (mem_i),
    .data_o      (st_data),
    .be_o        (st_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vreg_o    <= '0;
      vreg_be_o <= '0;
      mem_o     <= '0;
      mem_be_o  <= '0;
    end else if (is_store_i) begin
      vreg_o    <= vreg_i;
      vreg_be_o <= '0;
      mem_o     <= st_data;
      mem_be_o  <= st_be;
    end else begin
      vreg_o    <= ld_data;
      vreg_be_o <= ld_be;
      mem_o     <= mem_i;
      mem_be_o  <= '0;
    end
  end
endmodule

// File: rtl/vqr_align_chk.sv
module vqr_align_chk
  import vqr_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2:0]            op_i,
  input logic                  is_store_i,
  input logic [OFF_W-1:0]      off_i,
  input logic [OFF_W-1:0]      elem_i,
  input logic [LINE_W-1:0]     vreg_i,
  input logic [LINE_W-1:0]     mem_i,
  input logic [LINE_W-1:0]     vreg_o,
  input logic [LINE_BYTES-1:0] vreg_be_o,
  input logic [LINE_W-1:0]     mem_o,
  input logic [LINE_BYTES-1:0] mem_be_o
);
  function automatic logic [LINE_W-1:0] expand(input logic [LINE_BYTES-1:0] be);
    logic [LINE_W-1:0] m;
    m = '0;
    for (int i = 0; i < LINE_BYTES; i++) if (be[i]) m[LINE_W-1-8*i -: 8] = 8'hFF;
    return m;
  endfunction

  logic [LINE_BYTES-1:0] act_be;
  assign act_be = vreg_be_o | mem_be_o;

  AST_BYTE_LOAD_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 && !is_store_i) |=> vreg_be_o == (LINE_BYTES'(1) << $past(elem_i))); // R1
  AST_HEAD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4) |=> $countones(act_be) == LINE_BYTES - $past(off_i)); // R4
  AST_TAIL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5) |=> $countones(act_be) == $past(off_i)); // R5
  AST_TAIL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && off_i == '0) |=> act_be == '0); // R6
  AST_HEAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && off_i == '0) |=> &act_be); // R7
  AST_KEEP_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((vreg_o ^ $past(vreg_i)) & ~expand(vreg_be_o)) == '0); // R8
  AST_KEEP_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((mem_o ^ $past(mem_i)) & ~expand(mem_be_o)) == '0); // R8
  AST_NOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[2:1] == 2'b11) |=> act_be == '0); // R9
  AST_SILENT_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(is_store_i) ? vreg_be_o == '0 : mem_be_o == '0)); // R10
endmodule

bind vqr_align vqr_align_chk u_chk (.*);

// File: tb/tb_vqr_align.sv
module tb_vqr_align;
  localparam int CYC = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   op_i = '0;
  logic         is_store_i = 1'b0;
  logic [3:0]   off_i = '0;
  logic [3:0]   elem_i = '0;
  logic [127:0] vreg_i = '0;
  logic [127:0] mem_i = '0;
  logic [127:0] vreg_o, mem_o;
  logic [15:0]  vreg_be_o, mem_be_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  vqr_align dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .is_store_i(is_store_i),
    .off_i(off_i), .elem_i(elem_i), .vreg_i(vreg_i), .mem_i(mem_i),
    .vreg_o(vreg_o), .vreg_be_o(vreg_be_o), .mem_o(mem_o), .mem_be_o(mem_be_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic st,
      input logic [3:0] off, input logic [3:0] el,
      input logic [127:0] vr, input logic [127:0] mm,
      output logic [127:0] vo, output logic [15:0] vbe,
      output logic [127:0] mo, output logic [15:0] mbe);
    int rs, ms, n;
    vo = vr; mo = mm; vbe = '0; mbe = '0;
    rs = 0; ms = 0; n = 0;
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3: begin rs = int'(el); ms = int'(off); n = 1 << op; end
      3'd4: begin rs = 0; ms = int'(off); n = 16 - int'(off); end
      3'd5: begin rs = 16 - int'(off); ms = 0; n = int'(off); end
      default: n = 0;
    endcase
    for (int k = 0; k < n; k++) begin
      int r, m;
      r = rs + k; m = ms + k;
      if (r < 16 && m < 16) begin
        if (st) begin
          mo[127-8*m -: 8] = vr[127-8*r -: 8];
          mbe[m] = 1'b1;
        end else begin
          vo[127-8*r -: 8] = mm[127-8*m -: 8];
          vbe[r] = 1'b1;
        end
      end
    end
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic st);
    if (op < 3'd4) return st ? "R2" : "R1";
    if (op == 3'd4) return "R4";
    if (op == 3'd5) return "R5";
    return "R9";
  endfunction

  task automatic run(input string req, input logic [2:0] op, input logic st,
                     input logic [3:0] off, input logic [3:0] el,
                     input logic [127:0] vr, input logic [127:0] mm);
    logic [127:0] evo, emo;
    logic [15:0]  evbe, embe;
    op_i = op; is_store_i = st; off_i = off; elem_i = el; vreg_i = vr; mem_i = mm;
    model(op, st, off, el, vr, mm, evo, evbe, emo, embe);
    @(posedge clk);
    @(negedge clk);
    chk(req, "vreg_o", vreg_o, evo);
    chk(req, "vreg_be_o", {112'b0, vreg_be_o}, {112'b0, evbe});
    chk(req, "mem_o", mem_o, emo);
    chk(req, "mem_be_o", {112'b0, mem_be_o}, {112'b0, embe});
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] va, ma, acc;
    void'($urandom(32'h5eed_1234));
    va = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    ma = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

    // R11: reset state
    vreg_i = va; mem_i = ma; op_i = 3'd4;
    repeat (3) @(negedge clk);
    chk("R11", "vreg_o in reset", vreg_o, '0);
    chk("R11", "mem_o in reset", mem_o, '0);
    chk("R11", "masks in reset", {96'b0, vreg_be_o, mem_be_o}, '0);
    rst_ni = 1'b1;

    // R11: one-edge latency on first operation
    run("R11", 3'd0, 1'b0, 4'd3, 4'd5, va, ma);

    run("R7", 3'd4, 1'b0, 4'd0, 4'd0, va, ma);
    run("R7", 3'd4, 1'b1, 4'd0, 4'd0, va, ma);
    run("R6", 3'd5, 1'b0, 4'd0, 4'd0, va, ma);
    run("R6", 3'd5, 1'b1, 4'd0, 4'd0, va, ma);
    run("R9", 3'd6, 1'b0, 4'd7, 4'd2, va, ma);
    run("R9", 3'd7, 1'b1, 4'd7, 4'd2, va, ma);
    run("R3", 3'd3, 1'b0, 4'd12, 4'd0, va, ma);
    run("R3", 3'd3, 1'b1, 4'd0, 4'd12, va, ma);
    run("R3", 3'd1, 1'b0, 4'd15, 4'd15, va, ma);
    run("R8", 3'd2, 1'b0, 4'd4, 4'd8, va, ma);
    run("R8", 3'd2, 1'b1, 4'd9, 4'd1, va, ma);
    run("R10", 3'd4, 1'b1, 4'd5, 4'd0, va, ma);
    run("R10", 3'd5, 1'b0, 4'd5, 4'd0, va, ma);

    // R4 R5: head then tail at same offset rebuild the full vector
    acc = va;
    for (int o = 1; o < 16; o++) begin
      run("R4", 3'd4, 1'b0, 4'(o), 4'd0, acc, ma);
      acc = vreg_o;
      run("R5", 3'd5, 1'b0, 4'(o), 4'd0, acc, rnd128());
      acc = vreg_o;
    end

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic st;
      op = 3'($urandom_range(0, 7));
      st = 1'($urandom_range(0, 1));
      run(tag_of(op, st), op, st, 4'($urandom_range(0, 15)),
          4'($urandom_range(0, 15)), rnd128(), rnd128());
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule